// File: doc/BRIEF.md
# Packed Eight-Channel TDM Audio Serial Port

This block is a clock-master serial port that carries eight audio channels in each direction over a single data line, inside a fixed frame of 256 bit clocks. It divides the system clock down to a bit clock and derives a frame clock from it. The frame clock stays low for the whole left half of the frame and high for the whole right half, so it marks channel groups rather than single channels.

The frame holds eight 32-bit slots. Slots 0 to 3 carry left channels 1 to 4 and slots 4 to 7 carry right channels 1 to 4. Each slot holds one 24-bit sample, MSB first, followed by eight zero pad bits. Eight parallel transmit samples are captured at the start of every frame. The eight samples received over the same frame are handed back in parallel together with a one-cycle strobe. The two data directions share one bit counter, so an external loopback returns each transmitted frame unchanged.

Top module: `tdm_packed_port`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `bclk` is 1, `lrclk` is 0, `sdout` is 0, `rx_valid` is 0 and `rx_data` is all zeros.
- R2: `bclk` toggles every `half_div`+1 system clocks. Its first falling edge after reset comes `half_div`+1 cycles after reset is released.
- R3: A frame is exactly 256 `bclk` periods long, which is 512×(`half_div`+1) system clocks. The first falling edge of `bclk` after reset starts bit 0 of the first frame, and each later falling edge advances the bit index by one, wrapping from 255 to 0.
- R4: `lrclk` is 0 during bits 0–127 and 1 during bits 128–255. It changes only together with the falling edge of `bclk` that starts bit 0 or bit 128.
- R5: `tx_data` is sampled only at the falling edge that starts bit 0. Changing it later in the frame does not affect the frame being sent. Slot s carries `tx_data[24*s +: 24]`.
- R6: In each slot, bits 0–23 carry the sample MSB first and bits 24–31 are driven 0. Over a frame, the count of ones on `sdout` therefore equals the count of ones in the captured `tx_data`.
- R7: `sdout` changes only in the cycle in which `bclk` falls.
- R8: `sdin` is sampled when `bclk` rises. Bits 0–23 of slot s become `rx_data[24*s +: 24]`, MSB first. The pad bits 24–31 are ignored.
- R9: `rx_valid` is high for exactly one system clock, in the cycle in which `bclk` rises for bit 255. `rx_data` updates in that same cycle and holds its value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | 8 | Bit-clock half period, minus one, in system clocks |
| tx_data | input | 192 | Eight transmit samples; slot s at bits 24*s+23..24*s |
| sdin | input | 1 | Serial receive data |
| bclk | output | 1 | Generated bit clock |
| lrclk | output | 1 | Generated frame clock: low for left slots, high for right slots |
| sdout | output | 1 | Serial transmit data |
| rx_data | output | 192 | Eight received samples, same slot layout as tx_data |
| rx_valid | output | 1 | One-cycle strobe when a full receive frame is available |

## Verification
The hardest case to reach from the ports is a change of `tx_data` in the middle of a frame that has already been captured, combined with proof that the pad bits on both the send and receive paths stay inert. The bench loops `sdout` back to `sdin`, swaps `tx_data` a hundred cycles into the first frame, and expects the old pattern back at the end of that frame and the new pattern one frame later. An all-ones pattern then shows that exactly 192 ones leave per frame. A pseudo-random `sdin`, which also toggles during pad bits, is checked against a behavioural frame model. The bench then resets the block with a larger divider to recheck the bit-clock and frame periods.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // bit-clock edge events that happen at the current system clock edge
  typedef struct packed {
    logic fall;
    logic rise;
  } bclk_evt_t;
endpackage

// File: rtl/tdm_clkgen.sv
module tdm_clkgen
  import tdm_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_div,
  output logic             bclk,
  output logic             lrclk,
  output logic [IDX_W-1:0] bit_idx,
  output logic [IDX_W-1:0] nxt_idx,
  output bclk_evt_t        evt
);
  logic [DIV_W-1:0] div_cnt;
  logic             hit;

  assign hit      = (div_cnt >= half_div);
  assign evt.fall = hit & bclk;
  assign evt.rise = hit & ~bclk;
  assign nxt_idx  = bit_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      bclk    <= 1'b1;
      lrclk   <= 1'b0;
      bit_idx <= '1;
    end else if (hit) begin
      div_cnt <= '0;
      bclk    <= ~bclk;
      if (bclk) begin
        bit_idx <= nxt_idx;
        lrclk   <= nxt_idx[IDX_W-1];
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8,
  parameter int IDX_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fall,
  input  logic [IDX_W-1:0]          nxt_idx,
  input  logic [SAMPLE_W*SLOTS-1:0] tx_data,
  output logic                      sdout
);
  localparam int FRAME_BITS = SLOT_W * SLOTS;
  localparam int PAD        = SLOT_W - SAMPLE_W;

  logic [FRAME_BITS-1:0] fmt;
  logic [FRAME_BITS-1:0] sh;
  logic                  start;

  // lay out the whole frame: slot 0 first, sample MSB first, then pad zeros
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (PAD > 0) begin : g_pad
      assign fmt[FRAME_BITS-1-s*SLOT_W -: SLOT_W] =
        {tx_data[s*SAMPLE_W +: SAMPLE_W], {PAD{1'b0}}};
    end else begin : g_nopad
      assign fmt[FRAME_BITS-1-s*SLOT_W -: SLOT_W] = tx_data[s*SAMPLE_W +: SAMPLE_W];
    end
  end

  assign start = fall && (nxt_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      sdout <= 1'b0;
    end else if (fall) begin
      if (start) begin
        sdout <= fmt[FRAME_BITS-1];
        sh    <= {fmt[FRAME_BITS-2:0], 1'b0};
      end else begin
        sdout <= sh[FRAME_BITS-1];
        sh    <= {sh[FRAME_BITS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8,
  parameter int IDX_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rise,
  input  logic [IDX_W-1:0]          bit_idx,
  input  logic                      sdin,
  output logic [SAMPLE_W*SLOTS-1:0] rx_data,
  output logic                      rx_valid
);
  localparam int POS_W = $clog2(SLOT_W);
  localparam int SEL_W = IDX_W - POS_W;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SAMPLE_W - 1);

  logic [SEL_W-1:0]          slot;
  logic [POS_W-1:0]          pos;
  logic                      in_sample;
  logic                      last_bit;
  logic                      frame_end;
  logic [SAMPLE_W-2:0]       acc;
  logic [SAMPLE_W-1:0]       hold [SLOTS];
  logic [SAMPLE_W*SLOTS-1:0] flat;

  assign slot      = bit_idx[IDX_W-1:POS_W];
  assign pos       = bit_idx[POS_W-1:0];
  assign in_sample = (pos <= LAST_POS);
  assign last_bit  = (pos == LAST_POS);
  assign frame_end = rise && (bit_idx == '1);

  // per-slot sample store, written once per slot, no reset (RAM-friendly)
  always_ff @(posedge clk) begin
    if (rise && last_bit) hold[slot] <= {acc, sdin};
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_flat
    assign flat[s*SAMPLE_W +: SAMPLE_W] = hold[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= frame_end;
      if (rise && in_sample) acc <= {acc[SAMPLE_W-3:0], sdin};
      if (frame_end) rx_data <= flat;
    end
  end
endmodule

// File: rtl/tdm_packed_port.sv
module tdm_packed_port
  import tdm_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int SLOTS    = 8,
  parameter int DIV_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DIV_W-1:0]          half_div,
  input  logic [SAMPLE_W*SLOTS-1:0] tx_data,
  input  logic                      sdin,
  output logic                      bclk,
  output logic                      lrclk,
  output logic                      sdout,
  output logic [SAMPLE_W*SLOTS-1:0] rx_data,
  output logic                      rx_valid
);
  localparam int IDX_W = $clog2(SLOT_W * SLOTS);

  bclk_evt_t        evt;
  logic [IDX_W-1:0] bit_idx;
  logic [IDX_W-1:0] nxt_idx;

  tdm_clkgen #(.DIV_W(DIV_W), .IDX_W(IDX_W)) u_clkgen (
    .clk(clk), .rst(rst), .half_div(half_div), .bclk(bclk), .lrclk(lrclk),
    .bit_idx(bit_idx), .nxt_idx(nxt_idx), .evt(evt)
  );

  tdm_tx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst(rst), .fall(evt.fall), .nxt_idx(nxt_idx),
    .tx_data(tx_data), .sdout(sdout)
  );

  tdm_rx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst(rst), .rise(evt.rise), .bit_idx(bit_idx), .sdin(sdin),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/tdm_packed_port_chk.sv
module tdm_packed_port_chk #(
  parameter int IDX_W    = 8,
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24,
  parameter int BUS_W    = 192
) (
  input logic             clk,
  input logic             rst,
  input logic             bclk,
  input logic             lrclk,
  input logic             sdout,
  input logic             rx_valid,
  input logic [BUS_W-1:0] rx_data,
  input logic [IDX_W-1:0] bit_idx
);
  localparam int POS_W = $clog2(SLOT_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SAMPLE_W - 1);
  localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(SLOT_W * 4);

  p_sdout_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdout) |-> $fell(bclk));

  p_lrclk_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrclk) |-> $fell(bclk));

  p_lrclk_rise_at_half_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(lrclk) |-> (bit_idx == HALF_IDX));

  p_lrclk_fall_at_start_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(lrclk) |-> (bit_idx == '0));

  p_pad_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_idx[POS_W-1:0] > LAST_POS) |-> !sdout);

  p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_rxdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> rx_valid);

  p_valid_at_end_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (bclk && lrclk && (bit_idx == '1)));
endmodule

bind tdm_packed_port tdm_packed_port_chk #(
  .IDX_W(IDX_W), .SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .BUS_W(SAMPLE_W*SLOTS)
) u_chk (
  .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .sdout(sdout),
  .rx_valid(rx_valid), .rx_data(rx_data), .bit_idx(bit_idx)
);

// File: tb/test_tdm_packed_port.sv
module test_tdm_packed_port;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   half_div = 8'd0;
  logic [191:0] tx_data = '0;
  logic         loop = 1'b1;
  logic [15:0]  lfsr = 16'hACE1;
  logic         sdin, bclk, lrclk, sdout, rx_valid;
  logic [191:0] rx_data;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  localparam logic [191:0] PAT_A = {24'h123456, 24'hABCDEF, 24'h800001, 24'h7FFFFE,
                                    24'h0F0F0F, 24'hF0F0F0, 24'h000001, 24'hC35A96};
  localparam logic [191:0] PAT_B = {24'h5A5A5A, 24'h111111, 24'hFEDCBA, 24'h000000,
                                    24'hFFFFFF, 24'h2468AC, 24'h13579B, 24'h800000};
  localparam logic [191:0] PAT_C = {24'h0000FF, 24'hFF0000, 24'h00FF00, 24'hA5A5A5,
                                    24'h3C3C3C, 24'h999999, 24'h424242, 24'h010203};

  always #4 clk = ~clk;

  assign sdin = loop ? sdout : lfsr[0];

  tdm_packed_port i_tdm_packed_port (
    .clk(clk), .rst(rst), .half_div(half_div), .tx_data(tx_data), .sdin(sdin),
    .bclk(bclk), .lrclk(lrclk), .sdout(sdout), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [191:0] act,
                     input logic [191:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural frame model
  int           m_div, m_bit, m_slot, m_pos;
  bit           m_bclk, m_lr, m_sd, m_valid;
  logic [191:0] m_lat, m_buf, m_rx;

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_bclk = 1; m_bit = 255; m_lr = 0; m_sd = 0; m_valid = 0;
      m_lat = '0; m_buf = '0; m_rx = '0;
    end else begin
      m_valid = 0;
      if (m_div >= int'(half_div)) begin
        m_div = 0;
        if (m_bclk) begin
          m_bclk = 0;
          m_bit  = (m_bit + 1) % 256;
          if (m_bit == 0) m_lat = tx_data;
          m_lr   = (m_bit >= 128);
          m_slot = m_bit / 32;
          m_pos  = m_bit % 32;
          m_sd   = (m_pos < 24) ? m_lat[m_slot*24 + 23 - m_pos] : 1'b0;
        end else begin
          m_bclk = 1;
          m_slot = m_bit / 32;
          m_pos  = m_bit % 32;
          if (m_pos < 24) m_buf[m_slot*24 + 23 - m_pos] = sdin;
          if (m_bit == 255) begin
            m_valid = 1;
            m_rx    = m_buf;
          end
        end
      end else begin
        m_div++;
      end
    end
  end

  // per-cycle comparison and per-frame measurements
  bit prev_bclk, prev_valid, have_prev;
  int cyc, falls, lr_hi, ones;

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst) begin
      have_prev = 0; cyc = 0; falls = 0; lr_hi = 0; ones = 0;
      prev_bclk = 1; prev_valid = 0;
    end else begin
      chk(bclk === m_bclk, "R2 bclk vs model", 192'(bclk), 192'(m_bclk));
      chk(lrclk === m_lr, "R4 lrclk vs model", 192'(lrclk), 192'(m_lr));
      chk(sdout === m_sd, "R6 sdout vs model", 192'(sdout), 192'(m_sd));
      chk(rx_valid === m_valid, "R9 rx_valid vs model", 192'(rx_valid), 192'(m_valid));
      chk(rx_data === m_rx, "R8 rx_data vs model", rx_data, m_rx);
      cyc++;
      if (prev_bclk && !bclk) begin
        falls++;
        if (lrclk) lr_hi++;
        if (sdout) ones++;
      end
      if (prev_valid && rx_valid) chk(0, "R9 strobe wider than one cycle", 192'(2), 192'(1));
      if (rx_valid) begin
        if (have_prev) begin
          chk(falls == 256, "R3 bclk periods per frame", 192'(falls), 192'(256));
          chk(cyc == 512 * (int'(half_div) + 1), "R3 cycles per frame",
              192'(cyc), 192'(512 * (int'(half_div) + 1)));
          chk(lr_hi == 128, "R4 lrclk high bits per frame", 192'(lr_hi), 192'(128));
          chk(ones == $countones(m_lat), "R6 ones per frame (pads zero)",
              192'(ones), 192'($countones(m_lat)));
        end
        have_prev = 1; cyc = 0; falls = 0; lr_hi = 0; ones = 0;
      end
      prev_bclk  = bclk;
      prev_valid = rx_valid;
    end
  end

  task automatic wait_strobe();
    do @(negedge clk); while (!rx_valid);
  endtask

  task automatic first_fall(input string tag);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (bclk);
    chk(n == int'(half_div) + 1, tag, 192'(n), 192'(int'(half_div) + 1));
  endtask

  task automatic reset_check();
    chk(bclk === 1'b1, "R1 bclk reset", 192'(bclk), 192'(1));
    chk(lrclk === 1'b0, "R1 lrclk reset", 192'(lrclk), 192'(0));
    chk(sdout === 1'b0, "R1 sdout reset", 192'(sdout), 192'(0));
    chk(rx_valid === 1'b0, "R1 rx_valid reset", 192'(rx_valid), 192'(0));
    chk(rx_data === '0, "R1 rx_data reset", rx_data, '0);
  endtask

  initial begin
    // phase 1: fastest divider, loopback
    tx_data = PAT_A;
    repeat (4) @(negedge clk);
    reset_check();
    rst = 1'b0;
    first_fall("R2 first fall after reset, half_div=0");
    repeat (100) @(negedge clk);
    tx_data = PAT_B;                       // R5: mid-frame change must not leak
    wait_strobe();
    chk(rx_data === PAT_A, "R5 R8 loopback first frame keeps captured data", rx_data, PAT_A);
    wait_strobe();
    chk(rx_data === PAT_B, "R5 R8 loopback second frame", rx_data, PAT_B);
    tx_data = '1;                          // R6: all ones, pads must stay zero
    wait_strobe();
    wait_strobe();
    chk(rx_data === '1, "R6 R8 all-ones loopback", rx_data, '1);
    loop = 1'b0;                           // R8: random sdin, pads ignored
    wait_strobe();
    wait_strobe();
    chk(rx_data === m_rx, "R8 random sdin frame", rx_data, m_rx);
    repeat (3) @(negedge clk);
    chk(rx_data === m_rx, "R9 rx_data held after strobe", rx_data, m_rx);

    // phase 2: slower divider after a fresh reset
    rst = 1'b1;
    loop = 1'b1;
    half_div = 8'd2;
    tx_data = PAT_C;
    repeat (3) @(negedge clk);
    reset_check();
    rst = 1'b0;
    first_fall("R2 first fall after reset, half_div=2");
    wait_strobe();
    wait_strobe();
    wait_strobe();
    chk(rx_data === PAT_C, "R3 R8 loopback with half_div=2", rx_data, PAT_C);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule